// File: doc/BRIEF.md
# System Control Register Bank

This block is a bank of 32-bit control words reached over a plain word-addressed slave bus made of an address, a write strobe, write data, a read strobe and registered read data. It answers a 4 KiB byte window. Only the lower half of that window holds storage: 512 words, each selected by the byte address divided by four. A handful of words come out of reset holding fixed identification values, and reads of three particular status words always return two forced-high bits on top of whatever is stored.

The upper half of the window holds no storage. Any access there raises a one-cycle error pulse and reads return zero. One address in that half acts as a command port. Writing a value code there produces a one-cycle system reset request or power-off request pulse for the surrounding chip to act on. The block only raises these requests and does not sequence reset or power itself.

Top module: `sysctl_regbank`

## Requirements
- R1: A write with byte address below 0x800 replaces all 32 bits of word address[10:2]. A read of that word returns the stored value on `bus_rdata` in the cycle after `bus_rd` is sampled high.
- R2: After reset, word 0x40 reads as 0x05F20121, word 0x41 as 0x00000002, word 0x42 as 0x05F30121 and word 0x43 as 0x05F40121. Every other stored word reads as zero, and `bus_rdata` itself is zero.
- R3: A read at byte address 0x800 or above returns zero. A write there changes no stored word, including the word whose index equals the low nine bits of the address.
- R4: `access_err` is high for exactly the one cycle after each cycle in which a read or write is sampled at byte address 0x800 or above. It stays low for accesses below 0x800 and for idle cycles.
- R5: A write to byte address 0xF00 pulses `sys_reset_req` for one cycle, in the cycle after the write, when the data is 1 or 2. It pulses `power_off_req` when the data is 3. Any other data requests nothing. Such a write still raises `access_err` and stores nothing.
- R6: Reads of byte addresses 0x100, 0x108 and 0x10C (words 0x40, 0x42 and 0x43) return the stored word ORed with 0x30000000. The stored word keeps its written value, and other addresses, including 0x104, get no such bits.
- R7: `bus_rdata` holds its value in every cycle that follows a cycle without `bus_rd`, even while writes change the word it came from.
- R8: Address bits [1:0] are ignored, so 0x013 selects the same word as 0x010 and 0xF03 acts as the command address.
- R9: When a read and a write to the same word are sampled in the same cycle, the read returns the contents from before the write, and the write takes effect.
- R10: `sys_reset_req` and `power_off_req` are never high together, and a read of the command address raises neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address within the window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| access_err | output | 1 | One-cycle out-of-window access pulse |
| sys_reset_req | output | 1 | One-cycle system reset request |
| power_off_req | output | 1 | One-cycle power-off request |

## Verification
The hardest case to reach from the ports is the one where a reset default and a written value compete for the same word. This includes words that were written before a second reset, a read and a write to one word in the same cycle, and overlay words that were overwritten with zero. The stimulus writes the identification words and then applies a reset in the middle of the run. It reads them back through the overlay addresses, and then sends a long random mix of same-cycle reads and writes. The bench checks every one of these against a behavioural model. Upper-half writes whose low index bits alias stored words, such as the command address and word 0x1C0, are read back through the aliased word to show that nothing was stored.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int WORD_W = 32;

  localparam logic [WORD_W-1:0] FORCE_BITS = 32'h3000_0000;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_RESET = 2'd1,
    CMD_OFF   = 2'd2
  } cmd_kind_t;

  function automatic logic [WORD_W-1:0] boot_value(input int unsigned widx);
    case (widx)
      32'h40:  return 32'h05F2_0121;
      32'h41:  return 32'h0000_0002;
      32'h42:  return 32'h05F3_0121;
      32'h43:  return 32'h05F4_0121;
      default: return '0;
    endcase
  endfunction

  function automatic logic forced_word(input int unsigned widx);
    return (widx == 32'h40) || (widx == 32'h42) || (widx == 32'h43);
  endfunction

  function automatic cmd_kind_t classify_cmd(input logic [WORD_W-1:0] data);
    if (data == 32'd1 || data == 32'd2) return CMD_RESET;
    if (data == 32'd3)                  return CMD_OFF;
    return CMD_NONE;
  endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode #(
  parameter int ADDR_W   = 12,
  parameter int STORE_AW = 9,
  parameter int CMD_OFF  = 'hF00
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [STORE_AW-1:0] widx,
  output logic                outside,
  output logic                cmd_hit
);
  localparam int WIDX_W      = ADDR_W - 2;
  localparam int STORE_WORDS = 1 << STORE_AW;
  localparam logic [WIDX_W-1:0] LIMIT   = WIDX_W'(STORE_WORDS);
  localparam logic [WIDX_W-1:0] CMD_IDX = WIDX_W'(CMD_OFF >> 2);

  logic [WIDX_W-1:0] full_idx;
  logic              unused_lo;

  assign full_idx  = addr[ADDR_W-1:2];
  assign unused_lo = ^addr[1:0];
  assign widx      = full_idx[STORE_AW-1:0];
  assign outside   = (full_idx >= LIMIT);
  assign cmd_hit   = (full_idx == CMD_IDX);

endmodule

// File: rtl/sysctl_store.sv
module sysctl_store
  import sysctl_pkg::*;
#(
  parameter int STORE_AW = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [STORE_AW-1:0] wr_idx,
  input  logic [WORD_W-1:0]   wr_data,
  input  logic                rd_en,
  input  logic [STORE_AW-1:0] rd_idx,
  input  logic                rd_outside,
  output logic [WORD_W-1:0]   rd_data
);
  localparam int STORE_WORDS = 1 << STORE_AW;

  logic [WORD_W-1:0]      ram [STORE_WORDS];
  logic [WORD_W-1:0]      ram_q;
  logic [STORE_WORDS-1:0] touched;
  logic                   touched_q;
  logic                   outside_q;
  logic                   force_q;
  logic [WORD_W-1:0]      boot_q;

  // Plain single-port style array: read-first, no reset, so block RAM fits.
  always_ff @(posedge clk) begin
    if (wr_en) ram[wr_idx] <= wr_data;
    if (rd_en) ram_q <= ram[rd_idx];
  end

  // One flag per word: clear means the word still holds its boot value.
  always_ff @(posedge clk) begin
    if (rst)        touched <= '0;
    else if (wr_en) touched[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outside_q <= 1'b1;
      touched_q <= 1'b0;
      force_q   <= 1'b0;
      boot_q    <= '0;
    end else if (rd_en) begin
      outside_q <= rd_outside;
      touched_q <= touched[rd_idx];
      force_q   <= forced_word(int'(rd_idx));
      boot_q    <= boot_value(int'(rd_idx));
    end
  end

  always_comb begin
    if (outside_q) rd_data = '0;
    else           rd_data = (touched_q ? ram_q : boot_q) | (force_q ? FORCE_BITS : '0);
  end

endmodule

// File: rtl/sysctl_cmd.sv
module sysctl_cmd
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              cmd_hit,
  input  logic [WORD_W-1:0] wr_data,
  output logic              sys_reset_req,
  output logic              power_off_req
);
  cmd_kind_t kind;

  assign kind = (wr_en && cmd_hit) ? classify_cmd(wr_data) : CMD_NONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      sys_reset_req <= 1'b0;
      power_off_req <= 1'b0;
    end else begin
      sys_reset_req <= (kind == CMD_RESET);
      power_off_req <= (kind == CMD_OFF);
    end
  end

  a_r10_req_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(sys_reset_req && power_off_req));

  a_r5_off_code: assert property (@(posedge clk) disable iff (rst)
    (wr_en && cmd_hit && wr_data == 32'd3) |=> (power_off_req && !sys_reset_req));

endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
  import sysctl_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int STORE_AW = 9,
  parameter int CMD_OFF  = 'hF00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              access_err,
  output logic              sys_reset_req,
  output logic              power_off_req
);
  localparam int STORE_BYTES = 4 << STORE_AW;

  logic [STORE_AW-1:0] widx;
  logic                outside;
  logic                cmd_hit;
  logic                store_wr;

  sysctl_decode #(
    .ADDR_W   (ADDR_W),
    .STORE_AW (STORE_AW),
    .CMD_OFF  (CMD_OFF)
  ) u_decode (
    .addr    (bus_addr),
    .widx    (widx),
    .outside (outside),
    .cmd_hit (cmd_hit)
  );

  assign store_wr = bus_wr && !outside && !rst;

  sysctl_store #(
    .STORE_AW (STORE_AW)
  ) u_store (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (store_wr),
    .wr_idx     (widx),
    .wr_data    (bus_wdata),
    .rd_en      (bus_rd),
    .rd_idx     (widx),
    .rd_outside (outside),
    .rd_data    (bus_rdata)
  );

  sysctl_cmd u_cmd (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (bus_wr),
    .cmd_hit       (cmd_hit),
    .wr_data       (bus_wdata),
    .sys_reset_req (sys_reset_req),
    .power_off_req (power_off_req)
  );

  always_ff @(posedge clk) begin
    if (rst) access_err <= 1'b0;
    else     access_err <= (bus_rd || bus_wr) && outside;
  end

  a_r4_err_follows: assert property (@(posedge clk) disable iff (rst)
    ((bus_rd || bus_wr) && (int'(bus_addr) >= STORE_BYTES)) |=> access_err);

  a_r4_no_err_inside: assert property (@(posedge clk) disable iff (rst)
    (int'(bus_addr) < STORE_BYTES) |=> !access_err);

  a_r5_cmd_flags_err: assert property (@(posedge clk) disable iff (rst)
    (sys_reset_req || power_off_req) |-> access_err);

  a_r7_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

  a_r3_outside_read_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && int'(bus_addr) >= STORE_BYTES) |=> (bus_rdata == '0));

endmodule

// File: tb/test_sysctl_regbank.sv
`timescale 1ns/1ps
module test_sysctl_regbank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        access_err;
  logic        sys_reset_req;
  logic        power_off_req;

  always #2 clk = ~clk;

  sysctl_regbank i_sysctl_regbank (
    .clk           (clk),
    .rst           (rst),
    .bus_addr      (bus_addr),
    .bus_wr        (bus_wr),
    .bus_wdata     (bus_wdata),
    .bus_rd        (bus_rd),
    .bus_rdata     (bus_rdata),
    .access_err    (access_err),
    .sys_reset_req (sys_reset_req),
    .power_off_req (power_off_req)
  );

  int    checks = 0;
  int    fails  = 0;
  string phase  = "R2";
  bit    chk_en = 0;

  // Behavioural reference model
  logic [31:0] m_mem [512];
  logic [31:0] e_rdata;
  logic        e_err, e_rst, e_off;

  function automatic logic [31:0] m_boot(int w);
    if (w == 64) return 32'h05F20121;
    if (w == 65) return 32'h00000002;
    if (w == 66) return 32'h05F30121;
    if (w == 67) return 32'h05F40121;
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    int w;
    if (rst) begin
      for (int i = 0; i < 512; i++) m_mem[i] = m_boot(i);
      e_rdata = 0; e_err = 0; e_rst = 0; e_off = 0;
    end else begin
      w = int'(bus_addr) / 4;
      e_err = (bus_rd || bus_wr) && (w >= 512);
      e_rst = bus_wr && (w == 'h3C0) && (bus_wdata == 1 || bus_wdata == 2);
      e_off = bus_wr && (w == 'h3C0) && (bus_wdata == 3);
      if (bus_rd) begin
        if (w < 512) e_rdata = m_mem[w] | ((w == 64 || w == 66 || w == 67) ? 32'h30000000 : 32'h0);
        else         e_rdata = 0;
      end
      if (bus_wr && w < 512) m_mem[w] = bus_wdata;
    end
  end

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", phase, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en) begin
      check("rdata", bus_rdata, e_rdata);
      check("access_err", {31'b0, access_err}, {31'b0, e_err});
      check("sys_reset_req", {31'b0, sys_reset_req}, {31'b0, e_rst});
      check("power_off_req", {31'b0, power_off_req}, {31'b0, e_off});
    end
  end

  task automatic acc(bit r, bit w, logic [11:0] a, logic [31:0] d);
    @(posedge clk); #1;
    bus_rd = r; bus_wr = w; bus_addr = a; bus_wdata = d;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) acc(0, 0, 12'h0, 32'h0);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL %s watchdog expired actual=running expected=finished", phase);
    summary();
    $finish;
  end

  initial begin
    @(posedge clk);
    chk_en = 1;
    repeat (3) @(posedge clk);
    #1 rst = 0;

    // R2: boot values, with R6 overlay on 0x100/0x108/0x10C
    phase = "R2";
    acc(1, 0, 12'h100, 0); acc(1, 0, 12'h104, 0); acc(1, 0, 12'h108, 0);
    acc(1, 0, 12'h10C, 0); acc(1, 0, 12'h000, 0); acc(1, 0, 12'h7FC, 0);
    acc(1, 0, 12'h110, 0); idle(2);

    // R1: full-word writes and readback
    phase = "R1";
    acc(0, 1, 12'h000, 32'hDEADBEEF); acc(0, 1, 12'h004, 32'h12345678);
    acc(0, 1, 12'h7FC, 32'hFFFFFFFF); acc(0, 1, 12'h200, 32'hA5A5A5A5);
    acc(1, 0, 12'h000, 0); acc(1, 0, 12'h004, 0); acc(1, 0, 12'h7FC, 0);
    acc(1, 0, 12'h200, 0); idle(1);

    // R6: overlay on read only, stored value kept
    phase = "R6";
    acc(0, 1, 12'h100, 32'h0); acc(1, 0, 12'h100, 0);
    acc(0, 1, 12'h10C, 32'hCFFF0000); acc(1, 0, 12'h10C, 0);
    acc(0, 1, 12'h104, 32'h0); acc(1, 0, 12'h104, 0);
    acc(0, 1, 12'h108, 32'h30000001); acc(1, 0, 12'h108, 0); idle(1);

    // R8: low address bits ignored
    phase = "R8";
    acc(0, 1, 12'h013, 32'h0BADF00D); acc(1, 0, 12'h010, 0);
    acc(1, 0, 12'h012, 0); acc(0, 1, 12'h0F1, 32'h77); acc(1, 0, 12'h0F0, 0); idle(1);

    // R3: outside reads are zero, outside writes store nothing (aliasing)
    phase = "R3";
    acc(1, 0, 12'h800, 0); acc(1, 0, 12'hFFC, 0);
    acc(0, 1, 12'h804, 32'h11111111); acc(1, 0, 12'h004, 0);
    acc(0, 1, 12'hF00, 32'h22222222); acc(1, 0, 12'h700, 0); idle(1);

    // R4: error pulse per outside access cycle, none inside
    phase = "R4";
    acc(1, 0, 12'h900, 0); acc(0, 1, 12'hA00, 5); acc(1, 1, 12'hB04, 6);
    idle(1); acc(1, 0, 12'h7FC, 0); acc(0, 1, 12'h7F8, 9); idle(2);

    // R5: command codes
    phase = "R5";
    acc(0, 1, 12'hF00, 32'd0); acc(0, 1, 12'hF00, 32'd1); acc(0, 1, 12'hF00, 32'd2);
    idle(1);
    acc(0, 1, 12'hF00, 32'd3); acc(0, 1, 12'hF00, 32'd4);
    acc(0, 1, 12'hF00, 32'hFFFFFFFF); acc(0, 1, 12'hF00, 32'h101);
    acc(0, 1, 12'hF03, 32'd1); acc(0, 1, 12'hF04, 32'd3); acc(1, 0, 12'h700, 0); idle(2);

    // R10: reads of the command address request nothing
    phase = "R10";
    acc(1, 0, 12'hF00, 32'd3); acc(1, 0, 12'hF00, 32'd1); idle(2);

    // R9: same-cycle read and write of one word returns prior contents
    phase = "R9";
    acc(0, 1, 12'h020, 32'hAAAA0000); acc(1, 1, 12'h020, 32'hBBBB1111);
    acc(1, 0, 12'h020, 0); acc(1, 1, 12'h100, 32'h5); acc(1, 0, 12'h100, 0); idle(1);

    // R7: rdata holds while writes change the source word
    phase = "R7";
    acc(1, 0, 12'h030, 0); acc(0, 1, 12'h030, 32'hCAFE0001);
    acc(0, 1, 12'h030, 32'hCAFE0002); idle(3); acc(1, 0, 12'h030, 0); idle(2);

    // R1: random mix
    phase = "R1";
    for (int i = 0; i < 3000; i++) begin
      logic [11:0] a;
      a = ($urandom % 4 == 0) ? 12'($urandom) : {3'b000, 2'b10, 5'($urandom), 2'($urandom)};
      if ($urandom % 8 == 0) a = 12'hF00;
      acc(1'($urandom), 1'($urandom), a, ($urandom % 3 == 0) ? 32'($urandom % 5) : $urandom);
    end
    idle(2);

    // R2: second reset restores boot values over written words
    phase = "R2";
    acc(0, 1, 12'h104, 32'h99); acc(0, 1, 12'h000, 32'h55);
    @(posedge clk); #1 rst = 1; bus_wr = 0; bus_rd = 0;
    repeat (2) @(posedge clk);
    #1 rst = 0;
    acc(1, 0, 12'h100, 0); acc(1, 0, 12'h104, 0); acc(1, 0, 12'h108, 0);
    acc(1, 0, 12'h10C, 0); acc(1, 0, 12'h000, 0); acc(1, 0, 12'h020, 0); idle(2);

    summary();
    $finish;
  end

endmodule